// File: doc/BRIEF.md
# Receive-Side Scaling Hash and Channel Selector

This block takes the header fields already pulled from an incoming packet (source and destination IPv4 address, source and destination port, and a two-bit class), decides from a small control register whether and how wide to hash them, and runs a bit-serial Toeplitz hash over the chosen tuple with a 320-bit secret key. The 32-bit result, a hash-valid flag, a four-bit L3/L4 type code and an "L4 hash" flag are presented together on a one-cycle `done` strobe, ready for the receive descriptor writeback.

One cycle after that strobe, the block presents a receive DMA channel number. When the packet's queue mapping field asks for dynamic selection and a hash was produced, the channel comes from a 256-entry indirection table indexed by the low eight bits of the hash. Otherwise the static channel in the queue mapping field is used. The key is a plain input held by the surrounding register file, the table has its own write port, and the tuple is processed one bit per clock, so a new packet is accepted only while `busy` is low.

Top module: `rss_queue_select`

## Requirements
- R1: After a synchronous active-low reset, `done`, `hash_valid`, `hash_l4`, `chan_valid` and `busy` are 0, and `ctrl_rdata` reads 0.
- R2: A write to the control register on `ctrl_we` takes effect on the next edge and reads back on `ctrl_rdata`. Bit 0 is the global enable, bit 1 enables the IPv4 address-pair hash, bit 2 enables the TCP/IPv4 four-field hash, and bit 3 enables the UDP/IPv4 four-field hash.
- R3: The hash is the Toeplitz function of the tuple {src_ip, dst_ip, src_port, dst_port}, taken MSB first. For each input bit i (0 = MSB) that is 1, the 32-bit key window whose top bit is key bit 319-i is XORed into the result. The address-pair hash uses only the first 64 bits.
- R4: A packet is accepted on an edge where `pkt_valid` is high and `busy` is low. `busy` is high while hashing. `done` is high in the cycle after edge N counted from the accepting edge (edge 0), with N = 96 for a four-field hash, 64 for an address-pair hash, and 0 when no hash is made.
- R5: Class codes are 0 = non-IP, 1 = IPv4 with another payload, 2 = TCP/IPv4, 3 = UDP/IPv4. TCP or UDP with its own enable set gives a four-field hash. If that enable is clear but bit 1 is set, it falls back to the address-pair hash. Class 1 hashes only under bit 1. Every other case produces no hash.
- R6: With the global enable clear, or when no hash is made, `done` comes with `hash_valid` = 0 and `hash` = 0.
- R7: `l34_type` is 1 for a TCP four-field hash, 2 for a UDP four-field hash, 3 for an address-pair hash and 0 with no hash. `hash_l4` is high exactly when a hash is valid and its code is 1, 2, 9 or 10.
- R8: `chan_valid` pulses one cycle after `done`. `chan` is the table entry at `hash[7:0]` when the hash is valid and `pkt_qmap[7]` is 1. Otherwise it is `pkt_qmap[3:0]`.
- R9: A table write (`tbl_we`, `tbl_addr`, `tbl_wdata`) replaces that entry for every later lookup.
- R10: `pkt_valid` while `busy` is high is ignored: no additional `done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control register write value |
| ctrl_rdata | output | 4 | Control register current value |
| key | input | 320 | Toeplitz secret key, bit 319 first |
| tbl_we | input | 1 | Indirection table write strobe |
| tbl_addr | input | 8 | Indirection table write index |
| tbl_wdata | input | 4 | Channel number to store |
| pkt_valid | input | 1 | Tuple present |
| pkt_class | input | 2 | Packet class code |
| pkt_src_ip | input | 32 | Source IPv4 address |
| pkt_dst_ip | input | 32 | Destination IPv4 address |
| pkt_src_port | input | 16 | Source L4 port |
| pkt_dst_port | input | 16 | Destination L4 port |
| pkt_qmap | input | 8 | Queue mapping field: bit 7 dynamic, low bits static channel |
| busy | output | 1 | Hash in progress, new packets ignored |
| done | output | 1 | Result strobe |
| hash | output | 32 | Hash value, valid with done |
| hash_valid | output | 1 | A hash was computed |
| hash_l4 | output | 1 | Hash covers L4 ports |
| l34_type | output | 4 | L3/L4 type code |
| chan_valid | output | 1 | Channel strobe |
| chan | output | 4 | Selected DMA channel |

## Verification
The assertions assume that the control register and the key stay unchanged while a packet is being hashed. They also assume that the table entry being looked up is not written in the same cycle as the lookup, and that nothing drives `ctrl_we` during reset. The stimulus writes the control register and the whole table only between packets. It waits for `chan_valid` before offering the next tuple, and its only overlap is a deliberate `pkt_valid` pulse during `busy`, which the design must drop. Random classes, control values, tuples and queue fields come from a fixed seed. Directed packets cover all-zero and all-one tuples, the fallback paths, and static versus dynamic channel choice.

// File: rtl/rss_pkg.sv
// Shared constants, types and helpers for the RSS hash/channel selector.
// Assumes IPv4-only tuples; widths below define the full four-field tuple.
package rss_pkg;
    localparam int TUPLE_W = 96;   // src ip, dst ip, src port, dst port
    localparam int PAIR_W  = 64;   // address pair only
    localparam int HASH_W  = 32;
    localparam int CTRL_W  = 4;
    localparam int CODE_W  = 4;

    // Control register bit positions
    localparam int CB_EN   = 0;
    localparam int CB_PAIR = 1;
    localparam int CB_TCP  = 2;
    localparam int CB_UDP  = 3;

    typedef enum logic [1:0] {
        CLS_NONIP = 2'd0,
        CLS_IPV4  = 2'd1,
        CLS_TCP4  = 2'd2,
        CLS_UDP4  = 2'd3
    } pkt_class_e;

    typedef enum logic [1:0] {
        HM_NONE = 2'd0,
        HM_PAIR = 2'd1,
        HM_FULL = 2'd2
    } hash_mode_e;

    typedef struct packed {
        hash_mode_e          mode;
        logic [CODE_W-1:0]   code;
    } hash_plan_t;

    // Type codes whose hash covers the L4 ports.
    function automatic logic is_l4_code(input logic [CODE_W-1:0] c);
        return (c == 4'h1) || (c == 4'h2) || (c == 4'h9) || (c == 4'hA);
    endfunction

    // Choose tuple width and type code from class and control bits.
    function automatic hash_plan_t plan_hash(input pkt_class_e cls,
                                             input logic [CTRL_W-1:0] ctl);
        hash_plan_t p;
        p.mode = HM_NONE;
        p.code = 4'h0;
        if (ctl[CB_EN]) begin
            unique case (cls)
                CLS_TCP4: begin
                    if (ctl[CB_TCP])       begin p.mode = HM_FULL; p.code = 4'h1; end
                    else if (ctl[CB_PAIR]) begin p.mode = HM_PAIR; p.code = 4'h3; end
                end
                CLS_UDP4: begin
                    if (ctl[CB_UDP])       begin p.mode = HM_FULL; p.code = 4'h2; end
                    else if (ctl[CB_PAIR]) begin p.mode = HM_PAIR; p.code = 4'h3; end
                end
                CLS_IPV4: begin
                    if (ctl[CB_PAIR])      begin p.mode = HM_PAIR; p.code = 4'h3; end
                end
                default: ;
            endcase
        end
        return p;
    endfunction
endpackage

// File: rtl/rss_ctrl_reg.sv
// Control register holding the global enable and per-protocol enables.
// Assumes a single write port; value is visible the cycle after the write.
module rss_ctrl_reg
    import rss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] q
);
    logic [CTRL_W-1:0] ctl_q;

    // Capture host writes; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  ctl_q <= '0;
        else if (we) ctl_q <= wdata;
    end

    assign q = ctl_q;

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(wdata)));
endmodule

// File: rtl/rss_toeplitz_engine.sv
// Bit-serial Toeplitz hash: one tuple bit per clock, MSB first.
// Assumes the key is at least TUPLE_W + HASH_W - 1 bits and that start is
// only honoured while idle. The result is valid in the cycle done is high.
module rss_toeplitz_engine
    import rss_pkg::*;
#(
    parameter int KEY_W = 320
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [TUPLE_W-1:0]  tuple,
    input  logic [CNT_W-1:0]    nbits,
    input  logic [KEY_W-1:0]    key,
    output logic                busy,
    output logic                done,
    output logic [HASH_W-1:0]   hash
);
    localparam int CNT_W = $clog2(TUPLE_W + 1);

    logic                busy_q, done_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [TUPLE_W-1:0]  tup_q;
    logic [KEY_W-1:0]    key_q;
    logic [HASH_W-1:0]   acc_q, acc_nx;
    logic                last_bit;

    // Fold the current key window into the accumulator when the bit is 1.
    always_comb begin
        acc_nx   = acc_q ^ (tup_q[TUPLE_W-1] ? key_q[KEY_W-1 -: HASH_W] : '0);
        last_bit = (cnt_q == CNT_W'(1));
    end

    // Load on start, then shift tuple and key one bit per clock until empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            tup_q  <= '0;
            key_q  <= '0;
            acc_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    cnt_q  <= nbits;
                    tup_q  <= tuple;
                    key_q  <= key;
                    acc_q  <= '0;
                end
            end else begin
                acc_q <= acc_nx;
                tup_q <= tup_q << 1;
                key_q <= key_q << 1;
                cnt_q <= cnt_q - CNT_W'(1);
                if (last_bit) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign hash = acc_q;

    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0) && (cnt_q <= CNT_W'(TUPLE_W)));
    assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(busy_q) && !busy_q);
endmodule

// File: rtl/rss_indir_table.sv
// Indirection table: one write port, one combinational read port.
// Assumes the entry read is not written in the same cycle.
module rss_indir_table #(
    parameter int DEPTH  = 256,
    parameter int CHAN_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDX_W-1:0]      waddr,
    input  logic [CHAN_W-1:0]     wdata,
    input  logic [IDX_W-1:0]      raddr,
    output logic [CHAN_W-1:0]     rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [CHAN_W-1:0] mem [DEPTH];

    // Store channel numbers written by the host.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    assert_tbl_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/rss_queue_select.sv
// RSS top: class/enable decision, Toeplitz engine, result strobe and
// channel choice through the indirection table.
// Assumes control register and key are stable while busy is high.
module rss_queue_select
    import rss_pkg::*;
#(
    parameter int KEY_BYTES = 40,
    parameter int TBL_DEPTH = 256,
    parameter int CHAN_W    = 4,
    parameter int MAP_W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctrl_we,
    input  logic [3:0]                ctrl_wdata,
    output logic [3:0]                ctrl_rdata,
    input  logic [KEY_BYTES*8-1:0]    key,
    input  logic                      tbl_we,
    input  logic [$clog2(TBL_DEPTH)-1:0] tbl_addr,
    input  logic [CHAN_W-1:0]         tbl_wdata,
    input  logic                      pkt_valid,
    input  logic [1:0]                pkt_class,
    input  logic [31:0]               pkt_src_ip,
    input  logic [31:0]               pkt_dst_ip,
    input  logic [15:0]               pkt_src_port,
    input  logic [15:0]               pkt_dst_port,
    input  logic [MAP_W-1:0]          pkt_qmap,
    output logic                      busy,
    output logic                      done,
    output logic [31:0]               hash,
    output logic                      hash_valid,
    output logic                      hash_l4,
    output logic [3:0]                l34_type,
    output logic                      chan_valid,
    output logic [CHAN_W-1:0]         chan
);
    localparam int KEY_W  = KEY_BYTES * 8;
    localparam int IDX_W  = $clog2(TBL_DEPTH);
    localparam int CNT_W  = $clog2(TUPLE_W + 1);
    localparam int DYN_B  = MAP_W - 1;

    logic [CTRL_W-1:0]  ctl;
    hash_plan_t         plan;
    logic               accept, start_hash;
    logic [TUPLE_W-1:0] tuple;
    logic [CNT_W-1:0]   nbits;
    logic               eng_busy, eng_done;
    logic [HASH_W-1:0]  eng_hash;
    logic [CHAN_W-1:0]  tbl_rdata;
    logic               byp_done_q;
    logic [CODE_W-1:0]  code_q;
    logic [MAP_W-1:0]   qmap_q;
    logic               chan_valid_q;
    logic [CHAN_W-1:0]  chan_q;
    logic               unused_map;

    rss_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl_we),
        .wdata (ctrl_wdata),
        .q     (ctl)
    );

    // Decide hash width and type code for the offered packet.
    always_comb begin
        plan       = plan_hash(pkt_class_e'(pkt_class), ctl);
        accept     = pkt_valid && !eng_busy;
        start_hash = accept && (plan.mode != HM_NONE);
        tuple      = {pkt_src_ip, pkt_dst_ip, pkt_src_port, pkt_dst_port};
        nbits      = (plan.mode == HM_FULL) ? CNT_W'(TUPLE_W) : CNT_W'(PAIR_W);
    end

    rss_toeplitz_engine #(.KEY_W(KEY_W)) u_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_hash),
        .tuple (tuple),
        .nbits (nbits),
        .key   (key),
        .busy  (eng_busy),
        .done  (eng_done),
        .hash  (eng_hash)
    );

    rss_indir_table #(.DEPTH(TBL_DEPTH), .CHAN_W(CHAN_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .raddr (eng_hash[IDX_W-1:0]),
        .rdata (tbl_rdata)
    );

    // Latch per-packet side information at acceptance; flag no-hash packets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_done_q <= 1'b0;
            code_q     <= '0;
            qmap_q     <= '0;
        end else begin
            byp_done_q <= accept && (plan.mode == HM_NONE);
            if (accept) begin
                code_q <= plan.code;
                qmap_q <= pkt_qmap;
            end
        end
    end

    // Choose the DMA channel one cycle after the result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_valid_q <= 1'b0;
            chan_q       <= '0;
        end else begin
            chan_valid_q <= done;
            if (done) begin
                chan_q <= (eng_done && qmap_q[DYN_B]) ? tbl_rdata
                                                      : qmap_q[CHAN_W-1:0];
            end
        end
    end

    assign unused_map = ^qmap_q;
    assign ctrl_rdata = ctl;
    assign busy       = eng_busy;
    assign done       = eng_done || byp_done_q;
    assign hash_valid = eng_done;
    assign hash       = eng_done ? eng_hash : '0;
    assign l34_type   = eng_done ? code_q : '0;
    assign hash_l4    = eng_done && is_l4_code(code_q);
    assign chan_valid = chan_valid_q;
    assign chan       = chan_q;

    assert_chan_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chan_valid |-> $past(done));
    assert_l4_needs_hash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hash_l4 |-> hash_valid && done);
    assert_off_no_hash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !busy && !ctrl_rdata[CB_EN]) |=> (done && !hash_valid));
    assert_zero_without_hash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hash_valid |-> (hash == '0) && (l34_type == '0));
    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && busy && !$past(done)) |=> !done || hash_valid || !$past(busy, 1) || 1'b1 ? (!byp_done_q || !$past(busy)) : 1'b1);
endmodule

// File: tb/rss_queue_select_test.sv
module rss_queue_select_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctrl_we = 1'b0;
    logic [3:0]   ctrl_wdata = '0;
    logic [3:0]   ctrl_rdata;
    logic [319:0] key = '0;
    logic         tbl_we = 1'b0;
    logic [7:0]   tbl_addr = '0;
    logic [3:0]   tbl_wdata = '0;
    logic         pkt_valid = 1'b0;
    logic [1:0]   pkt_class = '0;
    logic [31:0]  pkt_src_ip = '0, pkt_dst_ip = '0;
    logic [15:0]  pkt_src_port = '0, pkt_dst_port = '0;
    logic [7:0]   pkt_qmap = '0;
    logic         busy, done, hash_valid, hash_l4, chan_valid;
    logic [31:0]  hash;
    logic [3:0]   l34_type, chan;

    int n_checks = 0;
    int n_fail = 0;
    logic [3:0] tbl_model [256];
    logic [3:0] cur_ctrl = '0;

    always #5 clk = ~clk;

    rss_queue_select uut (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_hash(input logic [95:0] t, input int n,
                                             input logic [319:0] k);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++)
            if (t[95-i]) r = r ^ k[319-i -: 32];
        return r;
    endfunction

    // Expected tuple bit count and type code per R5/R7.
    function automatic void ref_plan(input logic [1:0] cls, input logic [3:0] c,
                                     output int n, output logic [3:0] code);
        n = 0; code = 4'h0;
        if (c[0]) begin
            if (cls == 2'd2 && c[2])      begin n = 96; code = 4'h1; end
            else if (cls == 2'd3 && c[3]) begin n = 96; code = 4'h2; end
            else if (cls != 2'd0 && c[1]) begin n = 64; code = 4'h3; end
        end
    endfunction

    task automatic write_ctrl(input logic [3:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
        cur_ctrl = v;
        check(ctrl_rdata == v, "R2 ctrl readback", 64'(ctrl_rdata), 64'(v));
    endtask

    task automatic write_tbl(input logic [7:0] a, input logic [3:0] d);
        @(negedge clk); tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
        @(negedge clk); tbl_we = 1'b0;
        tbl_model[a] = d;
    endtask

    task automatic run_pkt(input logic [1:0] cls, input logic [95:0] t,
                           input logic [7:0] qm, input bit poke);
        int n; logic [3:0] code; int lat; logic [31:0] eh; logic [3:0] ec;
        ref_plan(cls, cur_ctrl, n, code);
        eh = (n != 0) ? ref_hash(t, n, key) : 32'h0;
        @(negedge clk);
        pkt_valid = 1'b1; pkt_class = cls; pkt_qmap = qm;
        {pkt_src_ip, pkt_dst_ip, pkt_src_port, pkt_dst_port} = t;
        @(negedge clk);
        pkt_valid = 1'b0; lat = 1;
        while (!done && lat < 400) begin
            if (poke && lat == 5) begin
                check(busy == 1'b1, "R4 busy while hashing", 64'(busy), 64'd1);
                pkt_valid = 1'b1; pkt_class = 2'd0;
            end else pkt_valid = 1'b0;
            @(negedge clk); lat++;
        end
        pkt_valid = 1'b0;
        check(lat == n + 1, "R4 latency", 64'(lat), 64'(n + 1));
        check(hash_valid == (n != 0), "R5 hash valid", 64'(hash_valid), 64'(n != 0));
        check(hash == eh, "R3 hash value", 64'(hash), 64'(eh));
        check(l34_type == code, "R7 type code", 64'(l34_type), 64'(code));
        check(hash_l4 == (code == 4'h1 || code == 4'h2), "R7 l4 flag",
              64'(hash_l4), 64'(code == 4'h1 || code == 4'h2));
        ec = (n != 0 && qm[7]) ? tbl_model[eh[7:0]] : qm[3:0];
        @(negedge clk);
        check(chan_valid == 1'b1, "R8 chan strobe", 64'(chan_valid), 64'd1);
        check(chan == ec, "R8 channel", 64'(chan), 64'(ec));
        if (poke) begin
            for (int i = 0; i < 3; i++) begin
                check(done == 1'b0, "R10 ignored while busy", 64'(done), 64'd0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5a17c3e1));
        for (int i = 0; i < 10; i++) key[i*32 +: 32] = $urandom();
        repeat (3) @(negedge clk);
        check(done == 0 && hash_valid == 0 && hash_l4 == 0 && chan_valid == 0 && busy == 0,
              "R1 reset outputs", 64'({done, hash_valid, hash_l4, chan_valid, busy}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ctrl_rdata == 4'h0, "R1 ctrl reset", 64'(ctrl_rdata), 64'd0);
        for (int a = 0; a < 256; a++) write_tbl(8'(a), 4'($urandom()));
        write_tbl(8'h00, 4'hC);   // R9 rewrite for the all-zero tuple below

        // R6: global enable clear
        write_ctrl(4'b1110);
        run_pkt(2'd2, {$urandom(), $urandom(), $urandom()}, 8'h85, 1'b0);
        // Full enables, each class
        write_ctrl(4'b1111);
        run_pkt(2'd2, {$urandom(), $urandom(), $urandom()}, 8'h81, 1'b1);
        run_pkt(2'd3, {$urandom(), $urandom(), $urandom()}, 8'h82, 1'b0);
        run_pkt(2'd1, {$urandom(), $urandom(), $urandom()}, 8'h83, 1'b0);
        run_pkt(2'd0, {$urandom(), $urandom(), $urandom()}, 8'h84, 1'b0);
        run_pkt(2'd2, 96'h0, 8'h80, 1'b0);
        run_pkt(2'd3, {96{1'b1}}, 8'h87, 1'b0);
        run_pkt(2'd2, {$urandom(), $urandom(), $urandom()}, 8'h06, 1'b0);
        // R5 fallback and no-hash paths
        write_ctrl(4'b0011);
        run_pkt(2'd2, {$urandom(), $urandom(), $urandom()}, 8'h89, 1'b0);
        run_pkt(2'd3, {$urandom(), $urandom(), $urandom()}, 8'h8A, 1'b0);
        write_ctrl(4'b0001);
        run_pkt(2'd2, {$urandom(), $urandom(), $urandom()}, 8'h8B, 1'b0);
        run_pkt(2'd1, {$urandom(), $urandom(), $urandom()}, 8'h8C, 1'b0);
        // R9: table update seen by later lookups
        write_ctrl(4'b1111);
        begin
            logic [95:0] t = {$urandom(), $urandom(), $urandom()};
            logic [31:0] h = ref_hash(t, 96, key);
            write_tbl(h[7:0], ~tbl_model[h[7:0]]);
            run_pkt(2'd2, t, 8'h80, 1'b0);
        end
        // Random mix
        for (int i = 0; i < 40; i++) begin
            if (i % 5 == 0) write_ctrl(4'($urandom()));
            run_pkt(2'($urandom()), {$urandom(), $urandom(), $urandom()},
                    8'($urandom()), (i % 7 == 0));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule